// File: doc/BRIEF.md
# Quadrature Decoder with Windowed Velocity Capture

This block turns the two phase signals of an incremental encoder into a signed position count and a direction flag. It also measures speed. Every counted phase edge goes through a power-of-two predivider. The predivided pulses are then added up over a window set by a reloading down-counter, and the total for the window that just ended is held on an output for software to read. Software converts that total to a shaft speed. Four event sources feed a small interrupt unit: a phase error, a direction change, an index pulse and the end of a window. The unit provides raw status, a mask, masked status and write-one-to-clear.

The phase and index inputs each pass through two flip-flops before any decoding. The decoder is a four-state machine whose states match the phase pair {A,B}: `PH_00`, `PH_10`, `PH_11`, `PH_01`. In the forward direction the states follow the cycle `PH_00`→`PH_10`→`PH_11`→`PH_01`→`PH_00`. The reverse direction takes the opposite cycle. If both phases change at once, the state jumps to the diagonal and this counts as an error. The window timer has two states:
- `TMR_ARM` loads the programmed count and moves to `TMR_RUN` when the load value is non-zero.
- `TMR_RUN` counts down. At a count of 1 it signals expiry and reloads. It returns to `TMR_ARM` when the load value becomes zero.

When the predivider exponent changes, the predivider counter starts over from zero.

Top module: `qdec_top`

## Requirements
- R1: After reset, position is 0, dir is 0, velocity is 0, raw_status and masked_status are 0 and irq is 0.
- R2: With mode_4x=1, each change of a single phase steps position by +1 when it follows the forward cycle {A,B} 00→10→11→01→00 (A leads B), and by -1 when it follows the reverse cycle.
- R3: With mode_4x=0, only changes of phase A step position. A change of phase B alone leaves position unchanged.
- R4: dir is 0 after a counted forward step and 1 after a counted reverse step. Uncounted transitions leave it unchanged.
- R5: When both synchronized phases change in the same cycle, raw_status bit 0 is set and position does not change.
- R6: raw_status bit 1 is set by a counted step whose direction differs from the dir value left by the previous counted step.
- R7: A rising edge on index_in sets raw_status bit 2.
- R8: For a non-zero tmr_load of L, a window ends every L cycles. At that point velocity takes the number of predivided pulses in the window and raw_status bit 3 is set. A tmr_load of 0 keeps the timer idle.
- R9: With div_exp = N, one predivided pulse is produced for every 2^N counted steps (N=0 passes every step).
- R10: velocity counts pulses regardless of direction. Forward and reverse motion at the same rate give the same total.
- R11: Writing a 1 to an irq_clear bit clears that raw_status bit, unless the same source fires in that cycle. masked_status is raw_status AND irq_mask, and irq is high when any masked_status bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| index_in | input | 1 | Encoder index pulse (asynchronous) |
| mode_4x | input | 1 | 1: count A and B edges; 0: count A edges only |
| div_exp | input | EXP_W | Predivider exponent N, divide by 2^N |
| tmr_load | input | TMR_W | Window length in cycles, 0 holds the timer |
| irq_mask | input | 4 | Per-source enable for masked status |
| irq_clear | input | 4 | Write-one-to-clear for raw status |
| position | output | POS_W | Signed position count |
| dir | output | 1 | 0 forward, 1 reverse |
| velocity | output | VEL_W | Pulse total of the last completed window |
| raw_status | output | 4 | Bit 0 phase error, 1 direction change, 2 index, 3 window expiry |
| masked_status | output | 4 | raw_status AND irq_mask |
| irq | output | 1 | OR of masked_status |

## Verification
When a phase or index input is driven before clock edge k, the two synchronizer flops carry it to edge k+1. Position, dir and the matching raw_status bit then change at edge k+2. masked_status and irq follow raw_status with no further delay. The bench drives inputs on the falling edge and waits five whole cycles before it samples on a falling edge, which is later than every one of these paths. velocity changes only at a window expiry edge. For that reason each speed check runs the steady edge pattern for more than two windows, so that the value it reads belongs to a window that lay entirely inside the pattern.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    typedef enum logic {
        TMR_ARM = 1'b0,
        TMR_RUN = 1'b1
    } tmr_e;

    localparam int IRQ_N      = 4;
    localparam int IRQ_PERR   = 0;
    localparam int IRQ_DIRCHG = 1;
    localparam int IRQ_INDEX  = 2;
    localparam int IRQ_EXPIRE = 3;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= din;
            hold_q <= meta_q;
        end
    end

    assign dout = hold_q;
endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder
    import qdec_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    a_in,
    input  logic                    b_in,
    input  logic                    mode_4x,
    output logic signed [POS_W-1:0] pos,
    output logic                    dir,
    output logic                    step,
    output logic                    perr,
    output logic                    dirchg
);
    phase_e cur_q;
    phase_e obs;
    phase_e fwd_nxt;
    phase_e rev_nxt;
    logic signed [POS_W-1:0] pos_q;
    logic dir_q;
    logic moved, is_fwd, is_rev, a_moved;

    assign obs = phase_e'({a_in, b_in});

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= PH_00;
            pos_q <= '0;
            dir_q <= 1'b0;
        end else begin
            cur_q <= obs;
            if (step) begin
                pos_q <= is_rev ? pos_q - POS_W'(1) : pos_q + POS_W'(1);
                dir_q <= is_rev;
            end
        end
    end

    // transition decode
    always_comb begin
        unique case (cur_q)
            PH_00: begin fwd_nxt = PH_10; rev_nxt = PH_01; end
            PH_10: begin fwd_nxt = PH_11; rev_nxt = PH_00; end
            PH_11: begin fwd_nxt = PH_01; rev_nxt = PH_10; end
            PH_01: begin fwd_nxt = PH_00; rev_nxt = PH_11; end
            default: begin fwd_nxt = PH_00; rev_nxt = PH_00; end
        endcase
        moved   = (obs != cur_q);
        is_fwd  = moved && (obs == fwd_nxt);
        is_rev  = moved && (obs == rev_nxt);
        a_moved = (obs[1] != cur_q[1]);
        perr    = moved && !is_fwd && !is_rev;
        step    = (is_fwd || is_rev) && (mode_4x || a_moved);
        dirchg  = step && (is_rev != dir_q);
    end

    assign pos = pos_q;
    assign dir = dir_q;

    p_err_no_step_r5: assert property (@(posedge clk) disable iff (rst)
        perr |=> (pos_q == $past(pos_q)));

    p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pos_q != $past(pos_q)) |->
            ((pos_q - $past(pos_q) == POS_W'(1)) || ($past(pos_q) - pos_q == POS_W'(1))));

    p_b_only_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_4x && moved && !a_moved) |=> (pos_q == $past(pos_q)));

    p_dir_follows_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> (dir_q == $past(is_rev)));
endmodule

// File: rtl/qdec_prediv.sv
module qdec_prediv #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] div_exp,
    input  logic             edge_in,
    output logic             pulse
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W-1:0] mask;
    logic             exp_same;

    always_comb begin
        one_hot  = (CNT_W + 1)'(1) << div_exp;
        mask     = CNT_W'(one_hot - 1'b1);
        exp_same = (div_exp == exp_q);
        pulse    = edge_in && exp_same && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else begin
            exp_q <= div_exp;
            if (!exp_same)    cnt_q <= '0;
            else if (pulse)   cnt_q <= '0;
            else if (edge_in) cnt_q <= cnt_q + 1'b1;
        end
    end

    p_pulse_needs_edge_r9: assert property (@(posedge clk) disable iff (rst)
        pulse |-> edge_in);

    p_restart_on_exp_r9: assert property (@(posedge clk) disable iff (rst)
        (div_exp != exp_q) |=> (cnt_q == '0));
endmodule

// File: rtl/qdec_velocity.sv
module qdec_velocity
    import qdec_pkg::*;
#(
    parameter int TMR_W = 32,
    parameter int VEL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] load,
    input  logic             pulse,
    output logic [VEL_W-1:0] vel,
    output logic             expire
);
    tmr_e st_q, st_d;
    logic [TMR_W-1:0] timer_q;
    logic [VEL_W-1:0] acc_q;
    logic [VEL_W-1:0] vel_q;

    // state register and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= TMR_ARM;
            timer_q <= '0;
            acc_q   <= '0;
            vel_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == TMR_ARM || expire) timer_q <= load;
            else                           timer_q <= timer_q - 1'b1;
            if (st_q == TMR_ARM) begin
                acc_q <= '0;
            end else if (expire) begin
                vel_q <= acc_q + VEL_W'(pulse);
                acc_q <= '0;
            end else if (pulse) begin
                acc_q <= acc_q + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        unique case (st_q)
            TMR_ARM: if (load != '0) st_d = TMR_RUN;
            TMR_RUN: begin
                if (load == '0) st_d = TMR_ARM;
                expire = (timer_q <= TMR_W'(1));
            end
            default: st_d = TMR_ARM;
        endcase
    end

    assign vel = vel_q;

    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> (timer_q == $past(load)));

    p_acc_restart_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> (acc_q == '0));

    p_idle_no_expire_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == TMR_ARM) |-> !expire);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int POS_W = 32,
    parameter int VEL_W = 32,
    parameter int TMR_W = 32,
    parameter int EXP_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phase_a,
    input  logic                    phase_b,
    input  logic                    index_in,
    input  logic                    mode_4x,
    input  logic [EXP_W-1:0]        div_exp,
    input  logic [TMR_W-1:0]        tmr_load,
    input  logic [IRQ_N-1:0]        irq_mask,
    input  logic [IRQ_N-1:0]        irq_clear,
    output logic signed [POS_W-1:0] position,
    output logic                    dir,
    output logic [VEL_W-1:0]        velocity,
    output logic [IRQ_N-1:0]        raw_status,
    output logic [IRQ_N-1:0]        masked_status,
    output logic                    irq
);
    logic [2:0] sync_out;
    logic idx_q;
    logic step, perr, dirchg, div_pulse, expire, idx_rise;
    logic [IRQ_N-1:0] set_vec;
    logic [IRQ_N-1:0] raw_q;

    qdec_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({index_in, phase_a, phase_b}),
        .dout(sync_out)
    );

    qdec_decoder #(.POS_W(POS_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .a_in   (sync_out[1]),
        .b_in   (sync_out[0]),
        .mode_4x(mode_4x),
        .pos    (position),
        .dir    (dir),
        .step   (step),
        .perr   (perr),
        .dirchg (dirchg)
    );

    qdec_prediv #(.EXP_W(EXP_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .div_exp(div_exp),
        .edge_in(step),
        .pulse  (div_pulse)
    );

    qdec_velocity #(.TMR_W(TMR_W), .VEL_W(VEL_W)) u_vel (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .pulse (div_pulse),
        .vel   (velocity),
        .expire(expire)
    );

    assign idx_rise = sync_out[2] && !idx_q;

    always_comb begin
        set_vec             = '0;
        set_vec[IRQ_PERR]   = perr;
        set_vec[IRQ_DIRCHG] = dirchg;
        set_vec[IRQ_INDEX]  = idx_rise;
        set_vec[IRQ_EXPIRE] = expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 1'b0;
            raw_q <= '0;
        end else begin
            idx_q <= sync_out[2];
            raw_q <= (raw_q & ~irq_clear) | set_vec;
        end
    end

    assign raw_status    = raw_q;
    assign masked_status = raw_q & irq_mask;
    assign irq           = |masked_status;

    p_index_flag_r7: assert property (@(posedge clk) disable iff (rst)
        idx_rise |=> raw_q[IRQ_INDEX]);

    p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
        (|(irq_clear & ~set_vec)) |=> ((raw_q & $past(irq_clear & ~set_vec)) == '0));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    p_dirchg_flag_r6: assert property (@(posedge clk) disable iff (rst)
        dirchg |=> raw_q[IRQ_DIRCHG]);
endmodule

// File: tb/qdec_top_tb.sv
module qdec_top_tb_top;
    localparam int POS_W = 32;
    localparam int VEL_W = 32;
    localparam int TMR_W = 32;
    localparam int EXP_W = 3;
    localparam int NVEC  = 15;

    // entry: {mode_4x, phase{A,B}, expected dir, expected position[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b1, 2'b10, 1'b0, 8'd1},
        {1'b1, 2'b11, 1'b0, 8'd2},
        {1'b1, 2'b01, 1'b0, 8'd3},
        {1'b1, 2'b00, 1'b0, 8'd4},
        {1'b1, 2'b01, 1'b1, 8'd3},
        {1'b1, 2'b11, 1'b1, 8'd2},
        {1'b1, 2'b10, 1'b1, 8'd1},
        {1'b1, 2'b00, 1'b1, 8'd0},
        {1'b1, 2'b10, 1'b0, 8'd1},
        {1'b0, 2'b11, 1'b0, 8'd1},
        {1'b0, 2'b01, 1'b0, 8'd2},
        {1'b0, 2'b00, 1'b0, 8'd2},
        {1'b0, 2'b10, 1'b0, 8'd3},
        {1'b0, 2'b00, 1'b1, 8'd2},
        {1'b0, 2'b01, 1'b1, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0, mode_4x = 1'b1;
    logic [EXP_W-1:0] div_exp = '0;
    logic [TMR_W-1:0] tmr_load = '0;
    logic [3:0] irq_mask = '0, irq_clear = '0;
    logic signed [POS_W-1:0] position;
    logic dir, irq;
    logic [VEL_W-1:0] velocity;
    logic [3:0] raw_status, masked_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [1:0] ph = 2'b00;

    always #4 clk = ~clk;

    qdec_top #(.POS_W(POS_W), .VEL_W(VEL_W), .TMR_W(TMR_W), .EXP_W(EXP_W)) dut_i (
        .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .mode_4x(mode_4x), .div_exp(div_exp),
        .tmr_load(tmr_load), .irq_mask(irq_mask), .irq_clear(irq_clear),
        .position(position), .dir(dir), .velocity(velocity),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] next_ph(input logic [1:0] p, input bit rev);
        logic [1:0] r;
        case (p)
            2'b00: r = rev ? 2'b01 : 2'b10;
            2'b10: r = rev ? 2'b00 : 2'b11;
            2'b11: r = rev ? 2'b10 : 2'b01;
            default: r = rev ? 2'b11 : 2'b00;
        endcase
        return r;
    endfunction

    task automatic drive_ph(input logic [1:0] p);
        ph = p;
        phase_a = p[1];
        phase_b = p[0];
    endtask

    // one quadrature step every 4 cycles
    task automatic run_motion(input int cycles, input bit rev);
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk);
            if (i % 4 == 0) drive_ph(next_ph(ph, rev));
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        irq_clear = 4'hF;
        @(negedge clk);
        irq_clear = 4'h0;
        wait_cycles(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(3);
        // R1 reset state
        check("R1 position", position, 0);
        check("R1 dir", dir, 0);
        check("R1 velocity", velocity, 0);
        check("R1 raw_status", raw_status, 0);
        check("R1 irq", irq, 0);

        // vector walk: R2 for 4-edge rows, R3 for 2-edge rows, R4 dir
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode_4x = VEC[v][11];
            drive_ph(VEC[v][10:9]);
            wait_cycles(5);
            check(VEC[v][11] ? "R2 position" : "R3 position",
                  position, longint'($signed(VEC[v][7:0])));
            check("R4 dir", dir, VEC[v][8]);
        end

        // R6: reversals occurred during the walk
        check("R6 dirchg raw", raw_status[1], 1);
        // R11: write-one-to-clear
        clear_all();
        check("R11 cleared", raw_status, 0);

        // R5 phase error (both phases flip), R11 masking
        irq_mask = 4'h0;
        @(negedge clk);
        drive_ph(~ph);
        wait_cycles(5);
        check("R5 perr raw", raw_status[0], 1);
        check("R5 position held", position, 2);
        check("R11 masked off", masked_status, 0);
        check("R11 irq off", irq, 0);
        irq_mask = 4'b0001;
        wait_cycles(1);
        check("R11 masked on", masked_status, 1);
        check("R11 irq on", irq, 1);
        irq_mask = 4'h0;
        clear_all();

        // R7 index
        check("R7 index before", raw_status[2], 0);
        index_in = 1'b1;
        wait_cycles(3);
        index_in = 1'b0;
        wait_cycles(5);
        check("R7 index raw", raw_status[2], 1);
        clear_all();

        // R8 velocity window, R9 predivider, R10 direction independent
        mode_4x  = 1'b1;
        div_exp  = 3'd0;
        tmr_load = 400;
        run_motion(1000, 1'b0);
        check("R8 velocity div1", velocity, 100);
        check("R8 expiry raw", raw_status[3], 1);
        div_exp = 3'd1;
        run_motion(1000, 1'b0);
        check("R9 velocity div2", velocity, 50);
        div_exp = 3'd2;
        run_motion(1000, 1'b0);
        check("R9 velocity div4", velocity, 25);
        div_exp = 3'd0;
        run_motion(1000, 1'b1);
        check("R10 velocity reverse", velocity, 100);

        // R8 idle timer: load 0 gives no further expiry
        tmr_load = '0;
        wait_cycles(3);
        clear_all();
        wait_cycles(500);
        check("R8 idle no expiry", raw_status[3], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule